// File: doc/BRIEF.md
# Modem Operating Mode Control

This block holds the one-byte operating mode of a packet data modem and turns it into the control levels that the rest of the modem consumes. A host writes the byte with a one-cycle write strobe. The upper five bits each steer one feature: interrupt output gating, data polarity inversion, transmit/receive direction, scrambler enable and powersave. The lowest three bits are accepted on a write but steer nothing.

Several bits have side effects that unfold in time. Any write that flips the direction bit cancels the task in progress, which is shown as a one-cycle pulse. A switch from receive to transmit clears a ready flag for two bit periods, so that the transmit filter can settle before a new task starts. Leaving powersave drops a filter-settled flag for two bit periods. Bit periods are counted on a one-cycle bit-rate strobe. The scrambler may run only while the current task code names one of five data-carrying tasks. During every other task it is held in reset.

Top module: `modem_mode_ctrl`

## Requirements
- R1: `irq_n` is 0 exactly when mode bit 7 is 1 and `irq_status` is 1. Otherwise it is 1. It follows `irq_status` in the same cycle.
- R2: `inv_tx` and `inv_rx` both equal mode bit 6, starting in the cycle right after the write edge.
- R3: `tx_mode` equals mode bit 5 (1 = transmit, 0 = receive), starting in the cycle right after the write edge.
- R4: `task_cancel` is 1 for exactly the one cycle after a write edge whose bit 5 differs from the stored bit 5. It is 0 in every other cycle.
- R5: A write that changes bit 5 from 0 to 1 drops `tx_ready` in the next cycle. `tx_ready` returns to 1 in the cycle after the second `bit_stb` edge that follows the write.
- R6: With task code encoding 0 idle, 1 scrambled-sequence transmit, 2 data-block receive, 3 short-data receive, 4 short-data transmit, 5 data-block transmit, 6 sync transmit, 7 preamble transmit, `scr_hold` is 1 for codes 0, 6 and 7 and 0 for codes 1 to 5, whatever the value of bit 4.
- R7: `scr_run` is 1 only when mode bit 4 is 1 and the task code is one of codes 1 to 5.
- R8: `filt_en`, `clkx_en` and `txbuf_en` are all 0 while mode bit 3 (powersave) is 1, and all 1 while it is 0.
- R9: `filt_settled` is 0 while powersave is 1. A write that takes bit 3 from 1 to 0 keeps it 0 until the cycle after the second `bit_stb` edge that follows the write.
- R10: A new qualifying event (a receive-to-transmit write or a powersave exit) that arrives while its timer runs restarts that timer at two bit periods. A strobe in the same cycle as the event does not count.
- R11: After reset the mode is all zeros: `irq_n`=1, no inversion, receive, `scr_run`=0, enables on, `task_cancel`=0, `tx_ready`=1, `filt_settled`=1.
- R12: Mode bits 2 to 0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the mode byte |
| wr_data | input | 8 | Mode byte to write |
| bit_stb | input | 1 | One-cycle pulse per bit period |
| task_code | input | 3 | Code of the task in progress |
| irq_status | input | 1 | Interrupt status bit |
| irq_n | output | 1 | Active-low interrupt pin |
| inv_tx | output | 1 | Invert transmit data |
| inv_rx | output | 1 | Invert receive data |
| tx_mode | output | 1 | 1 = transmit, 0 = receive |
| scr_run | output | 1 | Scrambler running |
| scr_hold | output | 1 | Scrambler held in reset |
| filt_en | output | 1 | Filter enable |
| clkx_en | output | 1 | Clock extraction enable |
| txbuf_en | output | 1 | Transmit output buffer enable |
| task_cancel | output | 1 | One-cycle cancel of the current task |
| tx_ready | output | 1 | Transmit filter settled after direction change |
| filt_settled | output | 1 | Filters settled after leaving powersave |

## Verification
The assertions check on every cycle that the interrupt pin follows its gate, that the write edge carries the inversion and direction bits through, that a cancel pulse appears after exactly the direction-flipping writes, that a receive-to-transmit switch or a powersave exit drops the matching ready flag, and that scrambler run and reset never overlap. The exact two-strobe length of each settle interval, restarts in the middle of an interval, and the lack of any effect from the low three bits can only be shown by the bench's scenarios, which count strobes against a model of the requirements.

// File: rtl/modem_mode_pkg.sv
package modem_mode_pkg;

  // Task codes seen on task_code
  typedef enum logic [2:0] {
    TK_IDLE     = 3'd0,
    TK_SEQ_TX   = 3'd1,
    TK_BLK_RX   = 3'd2,
    TK_SHORT_RX = 3'd3,
    TK_SHORT_TX = 3'd4,
    TK_BLK_TX   = 3'd5,
    TK_SYNC_TX  = 3'd6,
    TK_PRE_TX   = 3'd7
  } task_e;

  // Active part of the mode byte, MSB first as written by the host
  typedef struct packed {
    logic irq_gate;
    logic invert;
    logic tx_dir;
    logic scr_req;
    logic psave;
  } mode_t;

  localparam int MODE_W = 8;
  localparam int TASK_W = 3;

  function automatic mode_t byte_to_mode(logic [MODE_W-1:0] b);
    return mode_t'(b[MODE_W-1 -: 5]);
  endfunction

  // Tasks during which the scrambler may leave reset
  function automatic logic scr_task_ok(logic [TASK_W-1:0] code);
    case (task_e'(code))
      TK_SEQ_TX, TK_BLK_RX, TK_SHORT_RX, TK_SHORT_TX, TK_BLK_TX: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic is_rx_to_tx(mode_t cur, mode_t nxt);
    return !cur.tx_dir && nxt.tx_dir;
  endfunction

  function automatic logic is_psave_exit(mode_t cur, mode_t nxt);
    return cur.psave && !nxt.psave;
  endfunction

endpackage

// File: rtl/mode_reg_core.sv
module mode_reg_core
  import modem_mode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MODE_W-1:0] wr_data,
  output mode_t             mode_q,
  output logic              cancel_q,
  output logic              rx2tx_ev,
  output logic              ps_exit_ev
);

  mode_t nxt_mode;
  logic  spare_unused;

  assign nxt_mode     = byte_to_mode(wr_data);
  assign spare_unused = ^wr_data[2:0];

  // events decoded against the stored byte, used by the timers
  assign rx2tx_ev   = wr_en && is_rx_to_tx(mode_q, nxt_mode);
  assign ps_exit_ev = wr_en && is_psave_exit(mode_q, nxt_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      cancel_q <= 1'b0;
    end else begin
      cancel_q <= wr_en && (nxt_mode.tx_dir != mode_q.tx_dir);
      if (wr_en) mode_q <= nxt_mode;
    end
  end

endmodule

// File: rtl/bit_period_timer.sv
module bit_period_timer #(
  parameter int PERIODS = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy
);

  localparam int CW = (PERIODS < 2) ? 1 : $clog2(PERIODS + 1);
  localparam logic [CW-1:0] LOAD = CW'(PERIODS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (start)          cnt <= LOAD;
    else if (tick && cnt != '0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);

endmodule

// File: rtl/scram_gate.sv
module scram_gate
  import modem_mode_pkg::*;
(
  input  logic              scr_req,
  input  logic [TASK_W-1:0] task_code,
  output logic              run,
  output logic              hold
);

  logic task_ok;

  assign task_ok = scr_task_ok(task_code);
  assign hold    = !task_ok;
  assign run     = scr_req && task_ok;

endmodule

// File: rtl/modem_mode_ctrl.sv
module modem_mode_ctrl
  import modem_mode_pkg::*;
#(
  parameter int SETTLE_BITS = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       bit_stb,
  input  logic [2:0] task_code,
  input  logic       irq_status,
  output logic       irq_n,
  output logic       inv_tx,
  output logic       inv_rx,
  output logic       tx_mode,
  output logic       scr_run,
  output logic       scr_hold,
  output logic       filt_en,
  output logic       clkx_en,
  output logic       txbuf_en,
  output logic       task_cancel,
  output logic       tx_ready,
  output logic       filt_settled
);

  mode_t mode_q;
  logic  rx2tx_ev, ps_exit_ev;
  logic  pause_busy, settle_busy;
  logic  powered;

  mode_reg_core u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .mode_q     (mode_q),
    .cancel_q   (task_cancel),
    .rx2tx_ev   (rx2tx_ev),
    .ps_exit_ev (ps_exit_ev)
  );

  bit_period_timer #(.PERIODS(SETTLE_BITS)) u_pause (
    .clk   (clk),
    .rst_n (rst_n),
    .start (rx2tx_ev),
    .tick  (bit_stb),
    .busy  (pause_busy)
  );

  bit_period_timer #(.PERIODS(SETTLE_BITS)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .start (ps_exit_ev),
    .tick  (bit_stb),
    .busy  (settle_busy)
  );

  scram_gate u_scr (
    .scr_req   (mode_q.scr_req),
    .task_code (task_code),
    .run       (scr_run),
    .hold      (scr_hold)
  );

  assign powered      = !mode_q.psave;
  assign irq_n        = !(mode_q.irq_gate && irq_status);
  assign inv_tx       = mode_q.invert;
  assign inv_rx       = mode_q.invert;
  assign tx_mode      = mode_q.tx_dir;
  assign filt_en      = powered;
  assign clkx_en      = powered;
  assign txbuf_en     = powered;
  assign tx_ready     = !pause_busy;
  assign filt_settled = powered && !settle_busy;

endmodule

// File: rtl/modem_mode_chk.sv
module modem_mode_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       irq_status,
  input logic       irq_n,
  input logic       inv_tx,
  input logic       inv_rx,
  input logic       tx_mode,
  input logic       scr_run,
  input logic       scr_hold,
  input logic       filt_en,
  input logic       task_cancel,
  input logic       tx_ready,
  input logic       filt_settled
);

  // R1
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_status |-> irq_n);

  // R2
  invert_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (inv_tx == $past(wr_data[6])) && (inv_rx == $past(wr_data[6])));

  // R3
  dir_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> tx_mode == $past(wr_data[5]));

  // R4
  cancel_on_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[5] != tx_mode) |=> task_cancel);

  // R4
  cancel_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> !task_cancel);

  // R5
  pause_on_rx2tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mode) |-> !tx_ready);

  // R6
  scr_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scr_run |-> !scr_hold);

  // R9
  settle_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(filt_en) |-> !filt_settled);

  // R9
  settle_off_in_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_en |-> !filt_settled);

endmodule

bind modem_mode_ctrl modem_mode_chk u_mode_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_en        (wr_en),
  .wr_data      (wr_data),
  .irq_status   (irq_status),
  .irq_n        (irq_n),
  .inv_tx       (inv_tx),
  .inv_rx       (inv_rx),
  .tx_mode      (tx_mode),
  .scr_run      (scr_run),
  .scr_hold     (scr_hold),
  .filt_en      (filt_en),
  .task_cancel  (task_cancel),
  .tx_ready     (tx_ready),
  .filt_settled (filt_settled)
);

// File: tb/modem_mode_ctrl_bench.sv
module modem_mode_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_stb = 1'b0;
  logic [2:0] task_code = '0;
  logic       irq_status = 1'b0;
  logic irq_n, inv_tx, inv_rx, tx_mode, scr_run, scr_hold;
  logic filt_en, clkx_en, txbuf_en, task_cancel, tx_ready, filt_settled;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  logic [7:0] m_mode = '0;
  int         m_pause = 0;
  int         m_settle = 0;
  logic       m_cancel = 1'b0;

  always #2.5 clk = ~clk;

  modem_mode_ctrl u_modem_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .bit_stb(bit_stb), .task_code(task_code), .irq_status(irq_status),
    .irq_n(irq_n), .inv_tx(inv_tx), .inv_rx(inv_rx), .tx_mode(tx_mode),
    .scr_run(scr_run), .scr_hold(scr_hold), .filt_en(filt_en),
    .clkx_en(clkx_en), .txbuf_en(txbuf_en), .task_cancel(task_cancel),
    .tx_ready(tx_ready), .filt_settled(filt_settled)
  );

  function automatic logic allow_scr(logic [2:0] c);
    return (c >= 3'd1) && (c <= 3'd5);
  endfunction

  function automatic logic [11:0] out_vec();
    return {irq_n, inv_tx, inv_rx, tx_mode, scr_run, scr_hold,
            filt_en, clkx_en, txbuf_en, task_cancel, tx_ready, filt_settled};
  endfunction

  task automatic chk(string req, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R1 irq_n", irq_n, !(m_mode[7] && irq_status));
    chk("R2 invert", {inv_tx, inv_rx}, {2{m_mode[6]}});
    chk("R3 direction", tx_mode, m_mode[5]);
    chk("R4 cancel", task_cancel, m_cancel);
    chk("R5 tx_ready", tx_ready, m_pause == 0);
    chk("R6 scr_hold", scr_hold, !allow_scr(task_code));
    chk("R7 scr_run", scr_run, m_mode[4] && allow_scr(task_code));
    chk("R8 enables", {filt_en, clkx_en, txbuf_en}, {3{!m_mode[3]}});
    chk("R9 settled", filt_settled, !m_mode[3] && m_settle == 0);
  endtask

  // one clock: drive at negedge, update model at posedge, compare after
  task automatic step(logic w, logic [7:0] d, logic s, logic [2:0] t, logic q);
    @(negedge clk);
    wr_en = w; wr_data = d; bit_stb = s; task_code = t; irq_status = q;
    @(posedge clk);
    m_cancel = w && (d[5] != m_mode[5]);
    if (w && d[5] && !m_mode[5]) m_pause = 2;
    else if (s && m_pause > 0) m_pause--;
    if (w && !d[3] && m_mode[3]) m_settle = 2;
    else if (s && m_settle > 0) m_settle--;
    if (w) m_mode = d;
    #1;
    check_all();
  endtask

  task automatic idle(int n, logic s);
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, s, task_code, irq_status);
  endtask

  initial begin
    #(5 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] snap;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    #1;
    // R11 reset state
    chk("R11 reset", out_vec(), 12'b1_00_0_0_1_111_0_1_1);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 8'h00, 1'b0, 3'd0, 1'b0);

    // R1 gating
    step(1'b1, 8'h80, 1'b0, 3'd0, 1'b0);
    step(1'b0, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R1 low when gated", irq_n, 1'b0);
    step(1'b1, 8'h00, 1'b0, 3'd0, 1'b1);
    chk("R1 released", irq_n, 1'b1);

    // R5 receive to transmit pause, strobe counting
    step(1'b1, 8'h20, 1'b1, 3'd0, 1'b0);
    chk("R5 pause start", {task_cancel, tx_ready}, 2'b10);
    idle(2, 1'b0);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    chk("R5 after one strobe", tx_ready, 1'b0);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    chk("R5 after two strobes", tx_ready, 1'b1);

    // R10 restart of pause: go rx, then tx, one strobe, tx->rx->tx again
    step(1'b1, 8'h00, 1'b0, 3'd0, 1'b0);
    step(1'b1, 8'h20, 1'b0, 3'd0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    step(1'b1, 8'h00, 1'b0, 3'd0, 1'b0);
    step(1'b1, 8'h20, 1'b0, 3'd0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    chk("R10 restarted pause", tx_ready, 1'b0);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    chk("R10 pause ends", tx_ready, 1'b1);

    // R8 R9 powersave and exit
    step(1'b1, 8'h28, 1'b0, 3'd0, 1'b0);
    chk("R8 powersave off enables", {filt_en, filt_settled}, 2'b00);
    step(1'b1, 8'h20, 1'b1, 3'd0, 1'b0);
    chk("R9 settle start", {filt_en, filt_settled}, 2'b10);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    step(1'b0, 8'h00, 1'b1, 3'd0, 1'b0);
    chk("R9 settled after two", filt_settled, 1'b1);

    // R6 R7 every task code with scrambler requested
    step(1'b1, 8'h30, 1'b0, 3'd0, 1'b0);
    for (int c = 0; c < 8; c++) begin
      step(1'b0, 8'h00, 1'b0, 3'(c), 1'b0);
      chk("R7 scr_run per code", scr_run, allow_scr(3'(c)));
    end

    // R12 low bits have no effect
    snap = out_vec();
    step(1'b1, 8'h37, 1'b0, 3'd7, 1'b0);
    chk("R12 low bits", out_vec(), snap);

    // R2 immediate inversion
    step(1'b1, 8'h77, 1'b0, 3'd7, 1'b0);
    chk("R2 invert now", {inv_tx, inv_rx}, 2'b11);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic w;
      w = ($urandom % 6) == 0;
      step(w, 8'($urandom), ($urandom % 3) == 0, 3'($urandom), 1'($urandom));
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule